// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours, day of week, day of month, month and two-digit year. A sub-second tick input is divided down to one step per second. Each step ripples through a carry chain that knows month lengths and leap years. Hours run in either 24-hour form or 12-hour form with a PM flag. A century flag inside the month byte flips each time the year wraps.

A serial front end owns the register port. It writes through a single-cycle write port and reads back through a registered read port, using the address map given below. Two sticky status flags report a stopped oscillator and a low supply. Both are set by input pins and are cleared by software writes.

Top module: `bcd_timekeeper`

## Requirements
- R1: A cycle with `rst` high leaves 00:00:00 in 24-hour mode, weekday 0, day 01, month 01 with the century flag clear, year 00, oscillator-stop flag set, low-voltage flag clear, and `rd_data_o` 0.
- R2: A prescaler counts `tick_i` pulses. On every TICKS_PER_SEC-th accepted pulse the seconds advance in the same clock edge. A tick in a cycle with `wr_en_i` high is not counted.
- R3: Seconds and minutes count BCD 00 to 59. The wrap from 59 to 00 carries into the next field in the same edge.
- R4: In 24-hour mode (control-1 bit 5 set) hours count BCD 00 to 23. The wrap 23 to 00 starts a new day.
- R5: In 12-hour mode bits 4:0 of the hour byte hold BCD 1 to 12 and bit 5 is PM. The order is 0x12 (midnight), 0x01 … 0x11, 0x32 (noon), 0x21 … 0x31, then 0x12 again. Only the step from 0x31 to 0x12 starts a new day.
- R6: On a new day, the day of month wraps to 01 after 28, 29, 30 or 31, depending on the month, and the month advances. February has 29 days when the BCD year is divisible by 4, counting 00 as divisible.
- R7: The weekday counts 0 to 6 and wraps to 0 on each new day.
- R8: After December 31 the month becomes 01 and the year advances. When the year wraps from 99 to 00, bit 7 of the month byte toggles. At no other time does it change without a write.
- R9: Write addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 14 control 1, 15 control 2. Data is stored masked with 0x7F, 0x7F, 0x3F, 0x07, 0x3F, 0x9F, 0xFF. No field advances in a write cycle. A write to seconds also zeroes the prescaler.
- R10: Control 2 bit 4 is the oscillator-stop flag and bit 6 is the low-voltage flag. They are set while `osc_fail_i` and `low_volt_i`, respectively, are high. A control-2 write loads each flag from its data bit, and a high input wins over the write.
- R11: `rd_data_o` shows, one cycle after the request, the register at `rd_addr_i` as it was at that edge. Control 1 reads mode at bit 5, control 2 reads the flags at bits 4 and 6, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sub-second tick pulse |
| osc_fail_i | input | 1 | Sets the oscillator-stop flag |
| low_volt_i | input | 1 | Sets the low-voltage flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 8 | Registered read data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD with PM at bit 5 in 12-hour mode |
| wday_o | output | 3 | Weekday 0 to 6 |
| day_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month BCD in bits 4:0, century at bit 7 |
| year_o | output | 8 | Year, BCD |
| mode24_o | output | 1 | 24-hour mode active |
| osc_stop_o | output | 1 | Oscillator-stop flag |
| low_volt_o | output | 1 | Low-voltage flag |

## Verification
A wrong carry decision inside the chain shows at the field outputs on the first edge where the faulty digit should change. A missed month length or leap decision, for example, produces a wrong day or month on the clock after the last second of that day. A prescaler that is off by one shows up as seconds that move one tick early or late, within one second of simulated ticks. Because every field is compared on every clock, a fault never has to travel to a later rollover before it is seen.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 8;

  localparam logic [ADDR_W-1:0] A_SEC  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'd1;
  localparam logic [ADDR_W-1:0] A_HOUR = 4'd2;
  localparam logic [ADDR_W-1:0] A_WDAY = 4'd3;
  localparam logic [ADDR_W-1:0] A_DAY  = 4'd4;
  localparam logic [ADDR_W-1:0] A_MON  = 4'd5;
  localparam logic [ADDR_W-1:0] A_YEAR = 4'd6;
  localparam logic [ADDR_W-1:0] A_CTL1 = 4'd14;
  localparam logic [ADDR_W-1:0] A_CTL2 = 4'd15;

  localparam logic [REG_W-1:0] M_SEC  = 8'h7F;
  localparam logic [REG_W-1:0] M_MIN  = 8'h7F;
  localparam logic [REG_W-1:0] M_HOUR = 8'h3F;
  localparam logic [REG_W-1:0] M_DAY  = 8'h3F;
  localparam logic [REG_W-1:0] M_MON  = 8'h9F;

  localparam int PM_BIT   = 5;
  localparam int CENT_BIT = 7;
  localparam int H24_BIT  = 5;
  localparam int STOP_BIT = 4;
  localparam int VLOW_BIT = 6;

  // next value of a two-digit BCD byte, no range check
  function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(input logic [REG_W-1:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [REG_W-1:0] month_last(input logic [4:0] m,
                                                  input logic [REG_W-1:0] y);
    case (m)
      5'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold,
  input  logic clear,
  output logic step
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign step = tick & ~hold & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear)       cnt <= '0;
    else if (tick && !hold) cnt <= step ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/tk_time_chain.sv
module tk_time_chain
  import tk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              mode24,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  sec,
  output logic [REG_W-1:0]  min,
  output logic [REG_W-1:0]  hour,
  output logic              day_step
);
  logic             sec_wrap, min_wrap, min_step, hour_step, midnight;
  logic [REG_W-1:0] hour_nx, low_inc;

  assign sec_wrap  = (sec == 8'h59);
  assign min_wrap  = (min == 8'h59);
  assign min_step  = step & sec_wrap;
  assign hour_step = min_step & min_wrap;
  assign low_inc   = bcd_inc({3'b000, hour[4:0]});
  assign day_step  = hour_step & midnight;

  always_comb begin
    hour_nx  = bcd_inc(hour);
    midnight = 1'b0;
    if (mode24) begin
      if (hour == 8'h23) begin
        hour_nx  = 8'h00;
        midnight = 1'b1;
      end
    end else if (hour[4:0] == 5'h11) begin
      hour_nx  = {2'b00, ~hour[PM_BIT], 5'h12};
      midnight = hour[PM_BIT];
    end else if (hour[4:0] == 5'h12) begin
      hour_nx = {2'b00, hour[PM_BIT], 5'h01};
    end else begin
      hour_nx = {2'b00, hour[PM_BIT], low_inc[4:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec  <= '0;
      min  <= '0;
      hour <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_SEC)  sec  <= wr_data & M_SEC;
      if (wr_addr == A_MIN)  min  <= wr_data & M_MIN;
      if (wr_addr == A_HOUR) hour <= wr_data & M_HOUR;
    end else begin
      if (step)      sec  <= sec_wrap ? 8'h00 : bcd_inc(sec);
      if (min_step)  min  <= min_wrap ? 8'h00 : bcd_inc(min);
      if (hour_step) hour <= hour_nx;
    end
  end
endmodule

// File: rtl/tk_date_chain.sv
module tk_date_chain
  import tk_pkg::*;
#(
  parameter int WDAYS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              day_step,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [WW-1:0]     wday,
  output logic [REG_W-1:0]  day,
  output logic [REG_W-1:0]  mon,
  output logic [REG_W-1:0]  year
);
  localparam int WW = $clog2(WDAYS);
  localparam logic [WW-1:0] WLAST = WW'(WDAYS - 1);

  logic [REG_W-1:0] last, mon_inc;
  logic             day_wrap, mon_step, mon_wrap, year_step, year_wrap;

  assign last      = month_last(mon[4:0], year);
  assign day_wrap  = (day >= last);
  assign mon_step  = day_step & day_wrap;
  assign mon_wrap  = (mon[4:0] == 5'h12);
  assign year_step = mon_step & mon_wrap;
  assign year_wrap = (year == 8'h99);
  assign mon_inc   = bcd_inc({3'b000, mon[4:0]});

  always_ff @(posedge clk) begin
    if (rst) begin
      wday <= '0;
      day  <= 8'h01;
      mon  <= 8'h01;
      year <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_WDAY) wday <= wr_data[WW-1:0] & WLAST | wr_data[WW-1:0];
      if (wr_addr == A_DAY)  day  <= wr_data & M_DAY;
      if (wr_addr == A_MON)  mon  <= wr_data & M_MON;
      if (wr_addr == A_YEAR) year <= wr_data;
    end else begin
      if (day_step) begin
        wday <= (wday == WLAST) ? '0 : wday + 1'b1;
        day  <= day_wrap ? 8'h01 : bcd_inc(day);
      end
      if (mon_step)
        mon <= {mon[CENT_BIT] ^ (year_step & year_wrap), 2'b00,
                mon_wrap ? 5'h01 : mon_inc[4:0]};
      if (year_step) year <= year_wrap ? 8'h00 : bcd_inc(year);
    end
  end
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       osc_fail_i,
  input  logic       low_volt_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [3:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [2:0] wday_o,
  output logic [7:0] day_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       mode24_o,
  output logic       osc_stop_o,
  output logic       low_volt_o
);
  logic             sec_step, day_step, wr_ctl2;
  logic [REG_W-1:0] rd_mux;

  assign wr_ctl2 = wr_en_i && (wr_addr_i == A_CTL2);

  tk_prescaler #(.DIV(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst(rst), .tick(tick_i), .hold(wr_en_i),
    .clear(wr_en_i && (wr_addr_i == A_SEC)), .step(sec_step)
  );

  tk_time_chain u_time (
    .clk(clk), .rst(rst), .step(sec_step), .mode24(mode24_o),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .sec(sec_o), .min(min_o), .hour(hour_o), .day_step(day_step)
  );

  tk_date_chain #(.WDAYS(7)) u_date (
    .clk(clk), .rst(rst), .day_step(day_step),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .wday(wday_o), .day(day_o), .mon(mon_o), .year(year_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode24_o   <= 1'b1;
      osc_stop_o <= 1'b1;
      low_volt_o <= 1'b0;
    end else begin
      if (wr_en_i && (wr_addr_i == A_CTL1)) mode24_o <= wr_data_i[H24_BIT];
      osc_stop_o <= (wr_ctl2 ? wr_data_i[STOP_BIT] : osc_stop_o) | osc_fail_i;
      low_volt_o <= (wr_ctl2 ? wr_data_i[VLOW_BIT] : low_volt_o) | low_volt_i;
    end
  end

  always_comb begin
    case (rd_addr_i)
      A_SEC:   rd_mux = sec_o;
      A_MIN:   rd_mux = min_o;
      A_HOUR:  rd_mux = hour_o;
      A_WDAY:  rd_mux = {5'b00000, wday_o};
      A_DAY:   rd_mux = day_o;
      A_MON:   rd_mux = mon_o;
      A_YEAR:  rd_mux = year_o;
      A_CTL1:  rd_mux = {2'b00, mode24_o, 5'b00000};
      A_CTL2:  rd_mux = {1'b0, low_volt_o, 1'b0, osc_stop_o, 4'b0000};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_mux;
  end
endmodule

// File: rtl/tk_checker.sv
module tk_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [3:0] wr_addr_i,
  input logic       osc_fail_i,
  input logic       low_volt_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [2:0] wday_o,
  input logic [7:0] day_o,
  input logic [7:0] mon_o,
  input logic [7:0] year_o,
  input logic       mode24_o,
  input logic       osc_stop_o,
  input logic       low_volt_o
);
  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (sec_o == 8'h00 && min_o == 8'h00 && hour_o == 8'h00 &&
             wday_o == 3'd0 && day_o == 8'h01 && mon_o == 8'h01 &&
             year_o == 8'h00 && mode24_o && osc_stop_o && !low_volt_o));

  a_r2_no_tick_no_second: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !wr_en_i) |=> $stable(sec_o));

  a_r9_write_freezes_minutes: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i != 4'd1) |=> $stable(min_o));

  a_r8_century_only_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && !(year_o == 8'h99 && mon_o[4:0] == 5'h12 && day_o == 8'h31))
      |=> $stable(mon_o[7]));

  a_r5_pm_flips_at_eleven: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && !mode24_o && hour_o[4:0] != 5'h11) |=> $stable(hour_o[5]));

  a_r10_stop_flag_set: assert property (@(posedge clk) disable iff (rst)
    osc_fail_i |=> osc_stop_o);

  a_r10_vlow_flag_set: assert property (@(posedge clk) disable iff (rst)
    low_volt_i |=> low_volt_o);
endmodule

bind bcd_timekeeper tk_checker u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .osc_fail_i(osc_fail_i), .low_volt_i(low_volt_i),
  .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
  .day_o(day_o), .mon_o(mon_o), .year_o(year_o), .mode24_o(mode24_o),
  .osc_stop_o(osc_stop_o), .low_volt_o(low_volt_o)
);

// File: tb/sim_bcd_timekeeper.sv
`timescale 1ns/1ps
module sim_bcd_timekeeper;
  localparam int DIVB = 2;

  logic       clk = 1'b0, rst = 1'b1, tick_i = 1'b0;
  logic       osc_fail_i = 1'b0, low_volt_i = 1'b0, wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o, sec_o, min_o, hour_o, day_o, mon_o, year_o;
  logic [2:0] wday_o;
  logic       mode24_o, osc_stop_o, low_volt_o;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  bcd_timekeeper #(.TICKS_PER_SEC(DIVB)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .osc_fail_i(osc_fail_i),
    .low_volt_i(low_volt_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .day_o(day_o), .mon_o(mon_o), .year_o(year_o), .mode24_o(mode24_o),
    .osc_stop_o(osc_stop_o), .low_volt_o(low_volt_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_pre, m_sec, m_min, m_hour, m_wday, m_day, m_mon, m_year, m_rd;
  bit  m_24, m_stop, m_vlow, m_live = 0;

  function automatic int b2i(input int b); return (b >> 4) * 10 + (b & 15); endfunction
  function automatic int i2b(input int x); return ((x / 10) << 4) | (x % 10); endfunction
  function automatic int dec_hour(input int raw, input bit h24);
    if (h24) return b2i(raw & 'h3F);
    return (b2i(raw & 'h1F) % 12) + (((raw & 'h20) != 0) ? 12 : 0);
  endfunction
  function automatic int enc_hour(input int h, input bit h24);
    if (h24) return i2b(h);
    return i2b((h + 11) % 12 + 1) | ((h >= 12) ? 'h20 : 0);
  endfunction
  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic int m_reg(input int a);
    case (a)
      0: return m_sec;  1: return m_min;  2: return m_hour; 3: return m_wday;
      4: return m_day;  5: return m_mon;  6: return m_year;
      14: return m_24 ? 'h20 : 0;
      15: return (m_stop ? 'h10 : 0) | (m_vlow ? 'h40 : 0);
      default: return 0;
    endcase
  endfunction

  task automatic m_second();
    int h, d, mo, y;
    if (b2i(m_sec) < 59) begin m_sec = i2b(b2i(m_sec) + 1); return; end
    m_sec = 0;
    if (b2i(m_min) < 59) begin m_min = i2b(b2i(m_min) + 1); return; end
    m_min = 0;
    h = (dec_hour(m_hour, m_24) + 1) % 24;
    m_hour = enc_hour(h, m_24);
    if (h != 0) return;
    m_wday = (m_wday + 1) % 7;
    d = b2i(m_day) + 1; mo = b2i(m_mon & 'h1F); y = b2i(m_year);
    if (d <= dim(mo, y)) begin m_day = i2b(d); return; end
    m_day = 1; mo++;
    if (mo <= 12) begin m_mon = (m_mon & 'h80) | i2b(mo); return; end
    m_mon = (m_mon & 'h80) | 1;
    y++;
    if (y == 100) begin y = 0; m_mon = m_mon ^ 'h80; end
    m_year = i2b(y);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0; m_day = 1;
      m_mon = 1; m_year = 0; m_24 = 1; m_stop = 1; m_vlow = 0; m_rd = 0;
    end else begin
      m_rd = m_reg(int'(rd_addr_i));
      if (wr_en_i) begin
        case (wr_addr_i)
          4'd0: begin m_sec = wr_data_i & 'h7F; m_pre = 0; end
          4'd1: m_min = wr_data_i & 'h7F;
          4'd2: m_hour = wr_data_i & 'h3F;
          4'd3: m_wday = wr_data_i & 'h07;
          4'd4: m_day = wr_data_i & 'h3F;
          4'd5: m_mon = wr_data_i & 'h9F;
          4'd6: m_year = int'(wr_data_i);
          4'd14: m_24 = wr_data_i[5];
          4'd15: begin m_stop = wr_data_i[4]; m_vlow = wr_data_i[6]; end
          default: ;
        endcase
      end else if (tick_i) begin
        if (m_pre == DIVB - 1) begin m_pre = 0; m_second(); end
        else m_pre++;
      end
      if (osc_fail_i) m_stop = 1;
      if (low_volt_i) m_vlow = 1;
    end
    m_live = 1;
  end

  // compare every field on every clock, away from the active edge
  always @(negedge clk) if (m_live) begin
    chk("R3 seconds", sec_o, m_sec);
    chk("R3 minutes", min_o, m_min);
    chk(m_24 ? "R4 hour" : "R5 hour", hour_o, m_hour);
    chk("R7 weekday", wday_o, m_wday);
    chk("R6 day", day_o, m_day);
    chk("R8 month", mon_o, m_mon);
    chk("R8 year", year_o, m_year);
    chk("R9 mode", mode24_o, m_24);
    chk("R10 stop flag", osc_stop_o, m_stop);
    chk("R10 vlow flag", low_volt_o, m_vlow);
    chk("R11 read data", rd_data_o, m_rd);
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) begin @(negedge clk); tick_i = 1'b1; end
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic day_end(input logic [7:0] wd, d, mo, y);
    wr(4'd14, 8'h20); wr(4'd0, 8'h58); wr(4'd1, 8'h59); wr(4'd2, 8'h23);
    wr(4'd3, wd); wr(4'd4, d); wr(4'd5, mo); wr(4'd6, y);
    run(2 * DIVB);
  endtask

  task automatic hour12(input logic [7:0] h);
    wr(4'd14, 8'h00); wr(4'd0, 8'h58); wr(4'd1, 8'h59); wr(4'd2, h);
    run(2 * DIVB);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 sec", sec_o, 0); chk("R1 hour", hour_o, 0); chk("R1 day", day_o, 1);
    chk("R1 month", mon_o, 1); chk("R1 mode", mode24_o, 1);
    chk("R1 stop", osc_stop_o, 1); chk("R1 vlow", low_volt_o, 0);
    chk("R1 rd", rd_data_o, 0);
    rst = 1'b0;
    rd_addr_i = 4'd15;
    @(negedge clk); @(negedge clk);
    chk("R11 ctl2 read", rd_data_o, 'h10);

    // R2/R3 irregular ticks
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); tick_i = ($urandom % 3) != 0;
    end
    @(negedge clk); tick_i = 1'b0;

    // R2/R9 prescaler hold and clear
    wr(4'd0, 8'h10); run(1);
    @(negedge clk); tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 4'd1; wr_data_i = 8'h05;
    @(negedge clk); tick_i = 1'b0; wr_en_i = 1'b0;
    run(1); chk("R2 tick in write cycle ignored", sec_o, 'h11);
    run(1); wr(4'd0, 8'h20); run(1);
    chk("R9 seconds write clears prescaler", sec_o, 'h20);
    run(1); chk("R2 second after clear", sec_o, 'h21);

    // R9 masking
    wr(4'd0, 8'hD9); chk("R9 sec mask", sec_o, 'h59);
    wr(4'd5, 8'hE3); chk("R9 month mask", mon_o, 'h83);
    wr(4'd3, 8'hFD); chk("R9 weekday mask", wday_o, 5);

    // R4 / R6 / R7 / R8 rollovers
    day_end(8'h03, 8'h28, 8'h02, 8'h23);
    chk("R4 midnight", hour_o, 0); chk("R6 feb non-leap", mon_o, 'h03);
    chk("R7 weekday step", wday_o, 4);
    day_end(8'h00, 8'h28, 8'h02, 8'h24); chk("R6 feb leap", day_o, 'h29);
    day_end(8'h00, 8'h29, 8'h02, 8'h24); chk("R6 feb 29 end", mon_o, 'h03);
    day_end(8'h00, 8'h28, 8'h02, 8'h00); chk("R6 year 00 leap", day_o, 'h29);
    day_end(8'h00, 8'h28, 8'h02, 8'h12); chk("R6 year 12 leap", day_o, 'h29);
    day_end(8'h00, 8'h28, 8'h02, 8'h10); chk("R6 year 10 not leap", day_o, 'h01);
    day_end(8'h00, 8'h30, 8'h04, 8'h10); chk("R6 april end", mon_o, 'h05);
    day_end(8'h00, 8'h30, 8'h01, 8'h10); chk("R6 jan 30", day_o, 'h31);
    day_end(8'h06, 8'h31, 8'h01, 8'h10);
    chk("R6 jan end", mon_o, 'h02); chk("R7 weekday wrap", wday_o, 0);
    day_end(8'h00, 8'h31, 8'h12, 8'h41);
    chk("R8 new year", year_o, 'h42); chk("R8 no century", mon_o, 'h01);
    day_end(8'h00, 8'h31, 8'h12, 8'h99);
    chk("R8 century set", mon_o, 'h81); chk("R8 year wrap", year_o, 0);
    day_end(8'h00, 8'h31, 8'h92, 8'h99); chk("R8 century clear", mon_o, 'h01);

    // R5 twelve-hour sequence
    hour12(8'h11); chk("R5 noon", hour_o, 'h32);
    wr(4'd4, 8'h10);
    hour12(8'h31); chk("R5 midnight", hour_o, 'h12); chk("R5 day carry", day_o, 'h11);
    hour12(8'h12); chk("R5 after midnight", hour_o, 'h01);
    hour12(8'h32); chk("R5 after noon", hour_o, 'h21);
    hour12(8'h09); chk("R5 digit carry", hour_o, 'h10);
    run(300);

    // R10 flags
    wr(4'd15, 8'h00); chk("R10 write clears stop", osc_stop_o, 0);
    @(negedge clk); osc_fail_i = 1'b1; @(negedge clk); osc_fail_i = 1'b0;
    chk("R10 stop set", osc_stop_o, 1);
    @(negedge clk); low_volt_i = 1'b1;
    wr(4'd15, 8'h00); chk("R10 input wins", low_volt_o, 1);
    low_volt_i = 1'b0;
    wr(4'd15, 8'h00); chk("R10 vlow cleared", low_volt_o, 0);

    // R11 read sweep
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); rd_addr_i = 4'(a);
    end
    @(negedge clk); rd_addr_i = 4'd7;
    @(negedge clk); @(negedge clk); chk("R11 unmapped", rd_data_o, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule